// File: doc/BRIEF.md
# Hardware Lock Register Bank

This block holds a set of single-bit mutual-exclusion flags that several processors reach through one shared, single-port APB register interface. Each flag has its own word address. A processor acquires a flag by reading that address. If the read returns 0, the flag was free: the same read has set it, and the reader now owns it. If the read returns 1, another agent owns the flag and nothing changes. The owner frees the flag by writing zero to its address.

A read-only status word tells software how many flags the bank contains. The count appears as a one-hot multiplier of 32 in a four-bit field. The count is fixed by the parameter `LOCK_COUNT`, which must be 32, 64, 128 or 256. Accesses are handled one at a time, so a read that acquires a flag is atomic with respect to every other access.

Top module: `hwLockBank`

## Requirements
- R1: After reset every lock is free, so the first read of any implemented lock returns 0.
- R2: A read of a free lock returns 0, and that same access marks the lock as held.
- R3: A read of a held lock returns 1 and leaves it held.
- R4: A write of the value 0 to a lock address releases the lock, so the next read returns 0.
- R5: A write of any non-zero value to a lock address changes no lock.
- R6: Lock i is addressed at byte offset 0x800 + 4*i. Address bits [1:0] are ignored, and each lock is independent of the others.
- R7: A read of byte offset 0x14 returns a word in which only bits [27:24] may be set. That field holds LOCK_COUNT/32, which is one-hot: 1, 2, 4 or 8.
- R8: Writes to the status offset change neither the status word nor any lock.
- R9: Reads of unmapped offsets, and of lock indices at or beyond LOCK_COUNT, return 0 and change no state.
- R10: Of two back-to-back reads of the same free lock, only the first returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |

## Verification
Read data is combinational: it is valid during the access phase of the same transfer, and it reflects the lock state from before that transfer. Any state change from a read or a write takes effect on the clock edge that ends the access phase. The bench samples `prdata` one time unit after it raises `penable` at a falling edge, well before the next rising edge. It only checks the effect of an access through a later transfer, after that edge has passed. The expected values come from a bench-side model of the flags, which is updated only after each transfer completes.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int MAX_LOCKS = 256;
  localparam int IDX_W     = 8;
  localparam int DATA_W    = 32;

  // strobes from control to datapath, valid during the access phase
  typedef struct packed {
    logic             rdLock;    // read of an implemented lock
    logic             wrRelease; // write of zero to an implemented lock
    logic             rdStatus;  // read of the status word
    logic [IDX_W-1:0] idx;       // lock index
  } ctrlStrobes_t;
endpackage

// File: rtl/lockCtrl.sv
module lockCtrl
  import hwlock_pkg::*;
#(
  parameter int LOCK_COUNT = 32,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output ctrlStrobes_t      strobes
);
  localparam logic [IDX_W:0]    COUNT_L   = (IDX_W+1)'(LOCK_COUNT);
  localparam logic [ADDR_W-3:0] STATUS_WD = (ADDR_W-2)'(5); // 0x14 >> 2

  logic             access;
  logic             inLockRegion;
  logic             inRange;
  logic             isStatus;
  logic [IDX_W-1:0] idx;

  always_comb begin
    access       = psel && penable;
    inLockRegion = (paddr[ADDR_W-1:ADDR_W-2] == 2'b10);
    idx          = paddr[IDX_W+1:2];
    inRange      = ({1'b0, idx} < COUNT_L);
    isStatus     = (paddr[ADDR_W-1:2] == STATUS_WD);

    strobes.idx       = idx;
    strobes.rdLock    = access && !pwrite && inLockRegion && inRange;
    strobes.wrRelease = access &&  pwrite && inLockRegion && inRange && (pwdata == '0);
    strobes.rdStatus  = access && !pwrite && isStatus;
  end

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdLock, strobes.wrRelease, strobes.rdStatus}));
  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdLock || strobes.wrRelease) |-> ({1'b0, strobes.idx} < COUNT_L));
endmodule

// File: rtl/lockData.sv
module lockData
  import hwlock_pkg::*;
#(
  parameter int LOCK_COUNT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [3:0]        MULT        = 4'(LOCK_COUNT / 32);
  localparam logic [DATA_W-1:0] STATUS_WORD = {4'b0, MULT, 24'b0};

  logic [MAX_LOCKS-1:0] lockQ;

  initial begin
    count_param_chk: assert (LOCK_COUNT == 32 || LOCK_COUNT == 64 ||
                             LOCK_COUNT == 128 || LOCK_COUNT == 256);
  end

  for (genvar g = 0; g < MAX_LOCKS; g++) begin : gLock
    if (g < LOCK_COUNT) begin : gImpl
      logic hit;
      assign hit = (strobes.idx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (!rstN)                           lockQ[g] <= 1'b0;
        else if (hit && strobes.rdLock)      lockQ[g] <= 1'b1;
        else if (hit && strobes.wrRelease)   lockQ[g] <= 1'b0;
      end
    end else begin : gNone
      assign lockQ[g] = 1'b0;
    end
  end

  always_comb begin
    if (strobes.rdLock)        rdData = {31'b0, lockQ[strobes.idx]};
    else if (strobes.rdStatus) rdData = STATUS_WORD;
    else                       rdData = '0;
  end

  // R2
  acquire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdLock && !lockQ[strobes.idx]) |=> lockQ[$past(strobes.idx)]);
  // R3
  held_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdLock && lockQ[strobes.idx]) |=> lockQ[$past(strobes.idx)]);
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrRelease |=> !lockQ[$past(strobes.idx)]);
  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.rdLock && !strobes.wrRelease) |=> $stable(lockQ));
endmodule

// File: rtl/hwLockBank.sv
module hwLockBank
  import hwlock_pkg::*;
#(
  parameter int LOCK_COUNT = 32,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata
);
  ctrlStrobes_t strobes;

  lockCtrl #(.LOCK_COUNT(LOCK_COUNT), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .strobes(strobes)
  );

  lockData #(.LOCK_COUNT(LOCK_COUNT)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdData(prdata)
  );

  // R7
  status_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pwrite && paddr == ADDR_W'(12'h014)) |->
      (prdata[31:28] == 4'b0 && prdata[23:0] == 24'b0 && $onehot(prdata[27:24])));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pwrite && paddr[ADDR_W-1:ADDR_W-2] != 2'b10 &&
     paddr[ADDR_W-1:2] != (ADDR_W-2)'(5)) |-> (prdata == '0));
endmodule

// File: tb/sim_hwLockBank.sv
module sim_hwLockBank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata64, prdata128, prdata256;

  int checks = 0, fails = 0;
  bit expLock [256];
  logic [31:0] rd;

  always #5 clk = ~clk;

  hwLockBank #(.LOCK_COUNT(32)) u0 (.clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata));
  hwLockBank #(.LOCK_COUNT(64)) u1 (.clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata64));
  hwLockBank #(.LOCK_COUNT(128)) u2 (.clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata128));
  hwLockBank #(.LOCK_COUNT(256)) u3 (.clk(clk), .rstN(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata256));

  function automatic logic [11:0] lockAddr(int i);
    return 12'h800 + 12'(4 * i);
  endfunction

  function automatic logic [31:0] expStatus(int count);
    return {4'b0, 4'(count / 32), 24'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] v);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = v;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // model-checked lock read (R2/R3)
  task automatic modelRead(int i, string req);
    busRead(lockAddr(i), rd);
    check(req, rd, {31'b0, expLock[i]});
    expLock[i] = 1'b1;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: every implemented lock free after reset
    for (int i = 0; i < 32; i++) modelRead(i, "R1");
    for (int i = 0; i < 32; i++) begin busWrite(lockAddr(i), 0); expLock[i] = 0; end
    // R2 / R10: back-to-back acquire
    modelRead(5, "R2");
    modelRead(5, "R10");
    // R3: held stays held
    modelRead(5, "R3");
    // R5: non-zero writes ignored
    busWrite(lockAddr(5), 32'h1);
    busWrite(lockAddr(5), 32'hFFFF_FFFF);
    modelRead(5, "R5");
    // R4: release then reacquire
    busWrite(lockAddr(5), 0); expLock[5] = 0;
    modelRead(5, "R4");
    modelRead(5, "R4");
    // R6: neighbours independent, low address bits ignored
    modelRead(6, "R6");
    modelRead(4, "R6");
    busWrite(lockAddr(7) | 12'h3, 0); expLock[7] = 0;
    busRead(lockAddr(7) | 12'h2, rd); check("R6", rd, 32'h0); expLock[7] = 1;
    modelRead(7, "R6");
    // R7: status encoding for every count
    busRead(12'h014, rd); check("R7", rd, expStatus(32));
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 12'h014;
    @(negedge clk); penable = 1;
    #1 check("R7", prdata64, expStatus(64));
    check("R7", prdata128, expStatus(128));
    check("R7", prdata256, expStatus(256));
    @(negedge clk); psel = 0; penable = 0;
    // R8: status write ignored
    busWrite(12'h014, 32'h0);
    busWrite(12'h014, 32'hFFFF_FFFF);
    busRead(12'h014, rd); check("R8", rd, expStatus(32));
    modelRead(5, "R8");
    // R9: out-of-range and unmapped reads return 0 and change nothing
    busRead(lockAddr(32), rd); check("R9", rd, 32'h0);
    busRead(lockAddr(32), rd); check("R9", rd, 32'h0);
    busRead(lockAddr(255), rd); check("R9", rd, 32'h0);
    busRead(12'h010, rd); check("R9", rd, 32'h0);
    busRead(12'h400, rd); check("R9", rd, 32'h0);
    busRead(12'hC00, rd); check("R9", rd, 32'h0);
    modelRead(9, "R9");
    modelRead(31, "R9");
    // random mix, checked against the model
    for (int n = 0; n < 400; n++) begin
      int i;
      int op;
      i  = int'($urandom_range(0, 31));
      op = int'($urandom_range(0, 3));
      if (op == 0) begin busWrite(lockAddr(i), 0); expLock[i] = 0; end
      else if (op == 1) busWrite(lockAddr(i), 32'($urandom_range(1, 255)));
      else modelRead(i, "R2");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule